// File: doc/BRIEF.md
# Prioritized Interrupt Level Evaluator

This block decides whether a pending interrupt should be taken by the core. It receives two request vectors. The first holds software interrupt requests from the control register file. The second carries the external interrupt lines. From these it builds a summary of every pending request bit and finds the highest requested priority level. External levels always outrank software levels.

The winning level is compared with the current priority level of the processor. If the winning level is strictly higher, the block loads the summary and the winning level into its status registers. It also raises a one-cycle trap request toward the exception unit.

Evaluation does not run every cycle. It runs only after an arm strobe, which is typically issued on return from a handler, and running it disarms the block again. Asynchronous system trap requests are not serviced. If one is pending when evaluation runs, the block reports an error instead.

Top module: `irq_level_eval`

## Requirements
- R1: Software request bits 4 to 18 give priority levels 1 to 15, where the level is the bit index minus 3. Software bits 0 to 3 and 19 to 31 are ignored.
- R2: External line bits 20 to 31 give a priority level equal to their own bit index. External bits 0 to 19 are ignored.
- R3: The winning level is the highest pending level. Any pending external line wins over every software request.
- R4: A trap is requested only when the winning level is nonzero and strictly greater than `cur_ipl_i`.
- R5: When a trap is taken, two status outputs are loaded in the same cycle as `trap_o`. `irq_summary_o` receives the OR of all non-ignored pending software and external bits, each bit at its own position. `win_level_o` receives the winning level. At every other time both outputs hold their value.
- R6: Evaluation uses the inputs present in the cycle in which `armed_o` is 1. Its results appear on the next cycle. `trap_o` is high for exactly one cycle per successful evaluation, and never without a preceding armed cycle.
- R7: `arm_i` sets the armed flag on the next cycle. An evaluation clears the flag, unless `arm_i` is high again in that same cycle.
- R8: If `ast_req_i` is nonzero when evaluation runs, `ast_err_o` pulses for one cycle, no trap is raised, and the status outputs are unchanged.
- R9: After reset, `trap_o`, `armed_o` and `ast_err_o` are 0, and both status outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Arm strobe that requests one evaluation |
| sw_req_i | input | 32 | Software interrupt request vector (bits 4..18 used) |
| ext_irq_i | input | 32 | External interrupt lines (bits 20..31 used) |
| cur_ipl_i | input | 5 | Current processor priority level |
| ast_req_i | input | 4 | Asynchronous trap request field (must be zero) |
| trap_o | output | 1 | One-cycle interrupt trap request |
| armed_o | output | 1 | Evaluation armed flag |
| ast_err_o | output | 1 | One-cycle error pulse for an unsupported trap request |
| irq_summary_o | output | 32 | Registered pending-request summary |
| win_level_o | output | 5 | Registered winning priority level |

## Verification
The assertions check several rules on every cycle. A trap always follows an armed cycle. The trapped level exceeds the priority level seen at evaluation. A pending external bit in the summary forces an external-range level. The status registers stay still whenever no trap fires. An error pulse never coincides with a trap. The armed flag drops after an evaluation that is not re-armed.

The exact mapping from bit index to level cannot be shown by these properties, and neither can the masking of the ignored bit ranges or the equal-level boundary. Only the bench scenarios cover them, by comparing the outputs against an independent model over directed and random request patterns.

// File: rtl/irq_eval_pkg.sv
package irq_eval_pkg;

    localparam int DATA_W = 32;
    localparam int LVL_W  = 5;

    typedef struct packed {
        logic              armed;
        logic              trap;
        logic              err;
        logic [DATA_W-1:0] summary;
        logic [LVL_W-1:0]  level;
    } eval_state_t;

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int W     = 32,
    parameter int LO    = 4,
    parameter int HI    = 18,
    parameter int SUB   = 3,
    parameter int LVL_W = 5
) (
    input  logic [W-1:0]     vec_i,
    output logic             hit_o,
    output logic [LVL_W-1:0] lvl_o,
    output logic [W-1:0]     masked_o
);

    // keep only the bits inside the level window
    for (genvar g = 0; g < W; g++) begin : g_mask
        if (g >= LO && g <= HI) begin : g_in
            assign masked_o[g] = vec_i[g];
        end else begin : g_out
            assign masked_o[g] = 1'b0;
        end
    end

    // highest set bit wins: later iterations overwrite earlier ones
    always_comb begin
        hit_o = 1'b0;
        lvl_o = '0;
        for (int i = LO; i <= HI; i++) begin
            if (vec_i[i]) begin
                hit_o = 1'b1;
                lvl_o = LVL_W'(i - SUB);
            end
        end
    end

endmodule

// File: rtl/irq_level_select.sv
module irq_level_select #(
    parameter int LVL_W = 5
) (
    input  logic             sw_hit_i,
    input  logic [LVL_W-1:0] sw_lvl_i,
    input  logic             ext_hit_i,
    input  logic [LVL_W-1:0] ext_lvl_i,
    input  logic [LVL_W-1:0] cur_ipl_i,
    output logic [LVL_W-1:0] win_lvl_o,
    output logic             take_o
);

    always_comb begin
        if (ext_hit_i) begin
            win_lvl_o = ext_lvl_i;
        end else if (sw_hit_i) begin
            win_lvl_o = sw_lvl_i;
        end else begin
            win_lvl_o = '0;
        end
        take_o = (win_lvl_o != '0) && (win_lvl_o > cur_ipl_i);
    end

endmodule

// File: rtl/irq_level_eval.sv
module irq_level_eval
    import irq_eval_pkg::*;
#(
    parameter int SW_LO  = 4,
    parameter int SW_HI  = 18,
    parameter int EXT_LO = 20,
    parameter int EXT_HI = 31,
    parameter int AST_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic [DATA_W-1:0] sw_req_i,
    input  logic [DATA_W-1:0] ext_irq_i,
    input  logic [LVL_W-1:0]  cur_ipl_i,
    input  logic [AST_W-1:0]  ast_req_i,
    output logic              trap_o,
    output logic              armed_o,
    output logic              ast_err_o,
    output logic [DATA_W-1:0] irq_summary_o,
    output logic [LVL_W-1:0]  win_level_o
);

    localparam int SW_SUB = SW_LO - 1;
    localparam logic [DATA_W-1:0] EXT_MASK =
        (({DATA_W{1'b1}} >> (DATA_W - 1 - EXT_HI)) >> EXT_LO) << EXT_LO;

    eval_state_t st_d, st_q;

    logic              sw_hit, ext_hit, take;
    logic [LVL_W-1:0]  sw_lvl, ext_lvl, win_lvl;
    logic [DATA_W-1:0] sw_masked, ext_masked;

    irq_prio_enc #(
        .W(DATA_W), .LO(SW_LO), .HI(SW_HI), .SUB(SW_SUB), .LVL_W(LVL_W)
    ) u_sw_enc (
        .vec_i(sw_req_i), .hit_o(sw_hit), .lvl_o(sw_lvl), .masked_o(sw_masked)
    );

    irq_prio_enc #(
        .W(DATA_W), .LO(EXT_LO), .HI(EXT_HI), .SUB(0), .LVL_W(LVL_W)
    ) u_ext_enc (
        .vec_i(ext_irq_i), .hit_o(ext_hit), .lvl_o(ext_lvl), .masked_o(ext_masked)
    );

    irq_level_select #(
        .LVL_W(LVL_W)
    ) u_sel (
        .sw_hit_i(sw_hit), .sw_lvl_i(sw_lvl),
        .ext_hit_i(ext_hit), .ext_lvl_i(ext_lvl),
        .cur_ipl_i(cur_ipl_i),
        .win_lvl_o(win_lvl), .take_o(take)
    );

    always_comb begin
        st_d      = st_q;
        st_d.trap = 1'b0;
        st_d.err  = 1'b0;
        if (st_q.armed) begin
            st_d.armed = arm_i;
            if (ast_req_i != '0) begin
                st_d.err = 1'b1;
            end else if (take) begin
                st_d.trap    = 1'b1;
                st_d.summary = sw_masked | ext_masked;
                st_d.level   = win_lvl;
            end
        end else if (arm_i) begin
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trap_o        = st_q.trap;
    assign armed_o       = st_q.armed;
    assign ast_err_o     = st_q.err;
    assign irq_summary_o = st_q.summary;
    assign win_level_o   = st_q.level;

    AST_TRAP_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> $past(armed_o)); // R6
    AST_TRAP_ABOVE_IPL: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (win_level_o > $past(cur_ipl_i))); // R4
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_o |-> ($stable(irq_summary_o) && $stable(win_level_o))); // R5
    AST_EXT_PRECEDES: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_o && ((irq_summary_o & EXT_MASK) != '0)) |-> (int'(win_level_o) >= EXT_LO)); // R3
    AST_ERR_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ast_err_o |-> !trap_o); // R8
    AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_o && !arm_i) |=> !armed_o); // R7

endmodule

// File: tb/irq_level_eval_tb.sv
module irq_level_eval_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm_i = 1'b0;
    logic [31:0] sw_req_i = '0;
    logic [31:0] ext_irq_i = '0;
    logic [4:0]  cur_ipl_i = '0;
    logic [3:0]  ast_req_i = '0;
    logic        trap_o, armed_o, ast_err_o;
    logic [31:0] irq_summary_o;
    logic [4:0]  win_level_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] exp_sum = '0;
    logic [4:0]  exp_lvl = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_level_eval dut_i (
        .clk(clk), .rst_n(rst_n), .arm_i(arm_i),
        .sw_req_i(sw_req_i), .ext_irq_i(ext_irq_i),
        .cur_ipl_i(cur_ipl_i), .ast_req_i(ast_req_i),
        .trap_o(trap_o), .armed_o(armed_o), .ast_err_o(ast_err_o),
        .irq_summary_o(irq_summary_o), .win_level_o(win_level_o)
    );

    function automatic logic [4:0] model_level(logic [31:0] sw, logic [31:0] ext);
        logic [4:0] l = '0;
        for (int i = 4; i <= 18; i++) if (sw[i]) l = 5'(i - 3);
        for (int i = 20; i <= 31; i++) if (ext[i]) l = 5'(i);
        return l;
    endfunction

    function automatic logic [31:0] model_sum(logic [31:0] sw, logic [31:0] ext);
        return (sw & 32'h0007_FFF0) | (ext & 32'hFFF0_0000);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    // one arm/evaluate sequence with full result checking
    task automatic run_eval(logic [31:0] sw, logic [31:0] ext, logic [4:0] ipl,
                            logic [3:0] ast, string tag);
        logic [4:0] lvl;
        logic       exp_trap;
        logic       exp_err;
        lvl      = model_level(sw, ext);
        exp_err  = (ast != 0);
        exp_trap = !exp_err && (lvl != 0) && (lvl > ipl);
        sw_req_i = sw; ext_irq_i = ext; cur_ipl_i = ipl; ast_req_i = ast;
        arm_i = 1'b1;
        @(negedge clk);
        arm_i = 1'b0;
        check({tag, " R7 armed"}, 32'(armed_o), 32'd1);
        @(negedge clk);
        if (exp_trap) begin
            exp_sum = model_sum(sw, ext);
            exp_lvl = lvl;
        end
        check({tag, " R4 trap"}, 32'(trap_o), 32'(exp_trap));
        check({tag, " R8 err"}, 32'(ast_err_o), 32'(exp_err));
        check({tag, " R5 summary"}, irq_summary_o, exp_sum);
        check({tag, " R3 level"}, 32'(win_level_o), 32'(exp_lvl));
        check({tag, " R7 disarmed"}, 32'(armed_o), 32'd0);
        @(negedge clk);
        check({tag, " R6 pulse"}, 32'(trap_o), 32'd0);
        sw_req_i = '0; ext_irq_i = '0; ast_req_i = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R9 trap", 32'(trap_o), 0);
        check("R9 armed", 32'(armed_o), 0);
        check("R9 err", 32'(ast_err_o), 0);
        check("R9 summary", irq_summary_o, 0);
        check("R9 level", 32'(win_level_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_eval(32'h0000_0010, 0, 0, 0, "R1 lowest sw");
        run_eval(32'h0004_0000, 0, 0, 0, "R1 highest sw");
        run_eval(32'hFFF8_000F, 0, 0, 0, "R1 ignored sw");
        run_eval(0, 32'h000F_FFFF, 0, 0, "R2 ignored ext");
        run_eval(32'h0000_0100, 0, 5'd5, 0, "R4 equal level");
        run_eval(32'h0000_0100, 0, 5'd4, 0, "R4 one above");
        run_eval(32'h0007_FFF0, 32'h0010_0000, 5'd19, 0, "R3 ext over sw");
        run_eval(32'h0000_0200, 32'h8000_0000, 5'd30, 0, "R2 top ext");
        run_eval(0, 32'h8000_0000, 5'd31, 0, "R4 ipl max");
        run_eval(32'h0004_0000, 32'hFFF0_0000, 0, 4'h2, "R8 ast pending");

        // pending request without arming: nothing happens (R6)
        sw_req_i = 32'h0004_0000; ext_irq_i = 32'hFFF0_0000; cur_ipl_i = 0;
        repeat (3) begin
            @(negedge clk);
            check("R6 unarmed trap", 32'(trap_o), 0);
            check("R6 unarmed level", 32'(win_level_o), 32'(exp_lvl));
        end
        sw_req_i = '0; ext_irq_i = '0;

        for (int k = 0; k < 150; k++) begin
            logic [31:0] sw  = $urandom & $urandom;
            logic [31:0] ext = ($urandom % 3 == 0) ? ($urandom & $urandom) : 32'h0;
            logic [4:0]  ipl = 5'($urandom % 32);
            logic [3:0]  ast = ($urandom % 10 == 0) ? 4'(1 + $urandom % 15) : 4'h0;
            run_eval(sw, ext, ipl, ast, "R3 random");
        end
        finish_run();
    end

endmodule